// File: doc/BRIEF.md
# Flash Command Interface with Status

This block models the control side of a byte-wide parallel flash memory on a synchronous system clock. The host drives chip enable, write enable and output enable, all active low, together with an address and a byte of write data. Write cycles feed an unlock-and-command decoder that starts either a byte program or a sector erase. The block then runs the operation internally for a set number of clock cycles. A small internal cell array and a per-sector protection mask are part of the model.

While an operation is running, reads do not return array contents. They return a status byte instead:
- bit 7 is a completion flag (data polling).
- bit 6 inverts on every read.
- bit 5 flags an operation that ran past its time limit.
- bit 2 inverts on reads of the sector being erased.

A running erase can be suspended. While it is suspended, a byte can be programmed in another sector, and the erase can then be resumed. Timing is counted in clock cycles through parameters. The host bus strobes are assumed to be synchronous to the clock.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every location reads FFh, and the read data output holds FFh until the first read.
- R2: A program command is three writes: AAh at address 555h, then 55h at address 2AAh, then A0h at address 555h. The address is compared in full. The next write programs one byte, and the stored byte becomes the old contents ANDed with the written data. Programming can only clear bits.
- R3: While a program runs, status bit 7 reads as the complement of bit 7 of the byte being programmed, and bit 5 reads 0. After PROG_CYC cycles, reads return array data again.
- R4: While an operation is busy, bit 6 inverts on every read. The first busy read after reset returns 1. Once the operation ends, repeated reads return the same byte.
- R5: A sector erase is six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, and then 30h at any address inside the sector. The sector number is array index bits [ARR_W-1 -: SECT_W].
  - While the erase runs, bit 7 reads 0.
  - Reads of the erasing sector invert bit 2 on each read. Reads of other sectors return bit 2 as 0.
  - After ERASE_CYC active cycles, the erased sector reads FFh and other sectors keep their contents.
- R6: A write with the wrong data or the wrong address anywhere in a command sequence returns the decoder to idle. The writes that follow do not program anything.
- R7: A program or erase aimed at a sector whose PROT_MASK bit is set shows busy status for PROT_CYC cycles, with bit 6 inverting. The block then returns to array reads and the array data is unchanged.
- R8: Writing B0h during an erase suspends it.
  - Reads of the suspended sector return bit 7 = 1, bit 5 = 0, bit 6 frozen, and bit 2 inverting on each read.
  - Reads of other sectors return array data.
- R9: Writing 30h at any address while the erase is suspended resumes it. The erase continues from its remaining count, and a later B0h suspends it again.
- R10: A 30h write outside the suspended state is ignored. In read mode, reads still return array data afterwards.
- R11: A program issued while an erase is suspended shows program status with bit 6 inverting. When the program finishes, the block returns to the suspended state.
- R12: With FORCE_TIMEOUT set, an operation that reaches its cycle limit enters a failed state.
  - In that state, bit 5 reads 1, bit 7 follows R3/R5, and bit 6 keeps inverting.
  - The array is not changed.
  - Only a write of F0h returns the block to read mode.
- R13: The write address is taken when write enable falls. The write data is taken when write enable rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |

## Verification
Timing is counted from the clock edge that first samples the relevant strobe with chip enable low:
- **Reads:** when output enable is first sampled low, the byte read appears on `dout` two rising edges later.
- **Writes:** when write enable is first sampled high again, the write takes effect two edges later.
- **Operations:** an operation stays busy for its cycle count after that.

The bench drives the bus on falling clock edges and samples `dout` on the second falling edge after lowering output enable. Every status read is placed early inside a busy window. Every array read comes only after waiting the full program, erase or protect count plus a margin, so that no check falls near an operation boundary.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_PROT,
        ST_ERASE,
        ST_SUSP,
        ST_FAIL
    } op_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_U1,
        SQ_U2,
        SQ_PGM,
        SQ_E1,
        SQ_E2,
        SQ_E3
    } seq_state_e;

    typedef enum logic {
        OPK_PROG,
        OPK_ERASE
    } op_kind_e;

    typedef struct packed {
        logic       poll;
        logic       toggle;
        logic       timeout;
        logic [1:0] rsv_hi;
        logic       susp;
        logic [1:0] rsv_lo;
    } status_t;

    localparam logic [7:0]  CMD_UNLOCK1  = 8'hAA;
    localparam logic [7:0]  CMD_UNLOCK2  = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_SU = 8'h80;
    localparam logic [7:0]  CMD_SECT_ERS = 8'h30;
    localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0]  CMD_RESUME   = 8'h30;
    localparam logic [7:0]  CMD_RESET    = 8'hF0;
    localparam logic [15:0] UNLOCK_ADR_A = 16'h0555;
    localparam logic [15:0] UNLOCK_ADR_B = 16'h02AA;

    function automatic status_t pack_status(input logic poll, input logic tog,
                                            input logic tout, input logic susp);
        status_t s;
        s         = '0;
        s.poll    = poll;
        s.toggle  = tog;
        s.timeout = tout;
        s.susp    = susp;
        return s;
    endfunction

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
    parameter int ADDR_W = 12,
    parameter int ARR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_stb,
    output logic [ARR_W-1:0]  rd_idx
);

    logic              we_q;
    logic              oe_q;
    logic [ADDR_W-1:0] adr_lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b1;
            oe_q      <= 1'b1;
            adr_lat_q <= '0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_stb    <= 1'b0;
            rd_idx    <= '0;
        end else begin
            we_q   <= we_n;
            oe_q   <= oe_n;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            // address is taken on the falling write-enable edge
            if (!ce_n && we_q && !we_n)
                adr_lat_q <= addr;
            // data is taken on the rising write-enable edge
            if (!ce_n && !we_q && we_n) begin
                wr_stb  <= 1'b1;
                wr_addr <= adr_lat_q;
                wr_data <= din;
            end
            if (!ce_n && oe_q && !oe_n && we_n) begin
                rd_stb <= 1'b1;
                rd_idx <= addr[ARR_W-1:0];
            end
        end
    end

    // R13
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int ARR_W  = 7,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_en,
    input  logic [ARR_W-1:0]  pgm_idx,
    input  logic [7:0]        pgm_data,
    input  logic              ers_en,
    input  logic [SECT_W-1:0] ers_sect,
    input  logic [ARR_W-1:0]  rd_idx,
    output logic [7:0]        rd_data
);

    localparam int DEPTH  = 1 << ARR_W;
    localparam int OFS_W  = ARR_W - SECT_W;
    localparam int SECT_N = 1 << SECT_W;

    logic [7:0] cells [DEPTH];

    generate
        for (genvar s = 0; s < SECT_N; s++) begin : g_sect
            for (genvar o = 0; o < (1 << OFS_W); o++) begin : g_cell
                localparam int IDX = s * (1 << OFS_W) + o;
                always_ff @(posedge clk) begin
                    if (rst)
                        cells[IDX] <= 8'hFF;
                    else if (ers_en && ers_sect == SECT_W'(s))
                        cells[IDX] <= 8'hFF;
                    else if (pgm_en && pgm_idx == ARR_W'(IDX))
                        cells[IDX] <= cells[IDX] & pgm_data;
                end
            end
        end
    endgenerate

    assign rd_data = cells[rd_idx];

    // R2
    pgm_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (pgm_en && !ers_en) |=> ((cells[$past(pgm_idx)] & ~$past(pgm_data)) == 8'h00));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ARR_W     = 7,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 120,
    parameter int PROT_CYC  = 200,
    parameter bit FORCE_TIMEOUT = 1'b0,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output op_state_e         state_o,
    output op_kind_e          kind_o,
    output logic              prog_msb_o,
    output logic [SECT_W-1:0] esec_o,
    output logic              arr_pgm_en_o,
    output logic [ARR_W-1:0]  arr_pgm_idx_o,
    output logic [7:0]        arr_pgm_data_o,
    output logic              arr_ers_en_o
);

    localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ?
                             ((PROG_CYC > PROT_CYC) ? PROG_CYC : PROT_CYC) :
                             ((ERASE_CYC > PROT_CYC) ? ERASE_CYC : PROT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [ADDR_W-1:0] ADR_A = UNLOCK_ADR_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ADR_B = UNLOCK_ADR_B[ADDR_W-1:0];

    op_state_e         st_q;
    seq_state_e        seq_q, seq_d;
    op_kind_e          kind_q;
    logic [CNT_W-1:0]  pcnt_q, ecnt_q;
    logic [ARR_W-1:0]  pidx_q;
    logic [7:0]        pdat_q;
    logic [SECT_W-1:0] esec_q;
    logic              ret_susp_q;

    logic              accept_seq, go_prog, go_erase;
    logic              susp_cmd, resume_cmd, reset_cmd;
    logic [ARR_W-1:0]  w_idx;
    logic [SECT_W-1:0] w_sect;
    logic              hit_a, hit_b;

    assign w_idx      = wr_addr[ARR_W-1:0];
    assign w_sect     = w_idx[ARR_W-1 -: SECT_W];
    assign hit_a      = (wr_addr == ADR_A);
    assign hit_b      = (wr_addr == ADR_B);
    assign accept_seq = (st_q == ST_READ) || (st_q == ST_SUSP);

    always_comb begin
        seq_d    = seq_q;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        if (wr_stb) begin
            seq_d = SQ_IDLE;
            if (accept_seq) begin
                unique case (seq_q)
                    SQ_IDLE: if (hit_a && wr_data == CMD_UNLOCK1) seq_d = SQ_U1;
                    SQ_U1:   if (hit_b && wr_data == CMD_UNLOCK2) seq_d = SQ_U2;
                    SQ_U2: begin
                        if (hit_a && wr_data == CMD_PROGRAM)
                            seq_d = SQ_PGM;
                        else if (hit_a && wr_data == CMD_ERASE_SU && st_q == ST_READ)
                            seq_d = SQ_E1;
                    end
                    SQ_PGM:  go_prog = 1'b1;
                    SQ_E1:   if (hit_a && wr_data == CMD_UNLOCK1) seq_d = SQ_E2;
                    SQ_E2:   if (hit_b && wr_data == CMD_UNLOCK2) seq_d = SQ_E3;
                    SQ_E3:   if (wr_data == CMD_SECT_ERS) go_erase = 1'b1;
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end
    end

    assign susp_cmd   = wr_stb && (st_q == ST_ERASE) && (wr_data == CMD_SUSPEND);
    assign resume_cmd = wr_stb && (st_q == ST_SUSP) && (seq_q == SQ_IDLE)
                        && (wr_data == CMD_RESUME);
    assign reset_cmd  = wr_stb && (st_q == ST_FAIL) && (wr_data == CMD_RESET);

    // array updates coincide with the state leaving the busy window
    assign arr_pgm_en_o   = (st_q == ST_PROG) && (pcnt_q == '0) && !FORCE_TIMEOUT;
    assign arr_ers_en_o   = (st_q == ST_ERASE) && !susp_cmd && (ecnt_q == '0)
                            && !FORCE_TIMEOUT;
    assign arr_pgm_idx_o  = pidx_q;
    assign arr_pgm_data_o = pdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_READ;
            seq_q      <= SQ_IDLE;
            kind_q     <= OPK_PROG;
            pcnt_q     <= '0;
            ecnt_q     <= '0;
            pidx_q     <= '0;
            pdat_q     <= 8'hFF;
            esec_q     <= '0;
            ret_susp_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            unique case (st_q)
                ST_READ, ST_SUSP: begin
                    if (resume_cmd) begin
                        st_q   <= ST_ERASE;
                        kind_q <= OPK_ERASE;
                    end else if (go_prog) begin
                        pidx_q     <= w_idx;
                        pdat_q     <= wr_data;
                        kind_q     <= OPK_PROG;
                        ret_susp_q <= (st_q == ST_SUSP);
                        if (PROT_MASK[w_sect]) begin
                            st_q   <= ST_PROT;
                            pcnt_q <= CNT_W'(PROT_CYC - 1);
                        end else begin
                            st_q   <= ST_PROG;
                            pcnt_q <= CNT_W'(PROG_CYC - 1);
                        end
                    end else if (go_erase) begin
                        esec_q     <= w_sect;
                        kind_q     <= OPK_ERASE;
                        ret_susp_q <= 1'b0;
                        if (PROT_MASK[w_sect]) begin
                            st_q   <= ST_PROT;
                            pcnt_q <= CNT_W'(PROT_CYC - 1);
                        end else begin
                            st_q   <= ST_ERASE;
                            ecnt_q <= CNT_W'(ERASE_CYC - 1);
                        end
                    end
                end
                ST_PROG: begin
                    if (pcnt_q == '0) begin
                        if (FORCE_TIMEOUT)
                            st_q <= ST_FAIL;
                        else
                            st_q <= ret_susp_q ? ST_SUSP : ST_READ;
                    end else begin
                        pcnt_q <= pcnt_q - 1'b1;
                    end
                end
                ST_PROT: begin
                    if (pcnt_q == '0)
                        st_q <= ret_susp_q ? ST_SUSP : ST_READ;
                    else
                        pcnt_q <= pcnt_q - 1'b1;
                end
                ST_ERASE: begin
                    if (susp_cmd)
                        st_q <= ST_SUSP;
                    else if (ecnt_q == '0)
                        st_q <= FORCE_TIMEOUT ? ST_FAIL : ST_READ;
                    else
                        ecnt_q <= ecnt_q - 1'b1;
                end
                ST_FAIL: begin
                    if (reset_cmd)
                        st_q <= ST_READ;
                end
                default: st_q <= ST_READ;
            endcase
        end
    end

    assign state_o    = st_q;
    assign kind_o     = kind_q;
    assign prog_msb_o = pdat_q[7];
    assign esec_o     = esec_q;

    // R9
    resume_src_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ERASE && $past(st_q) == ST_SUSP)
            |-> $past(wr_stb && wr_data == CMD_RESUME));

    // R8
    susp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SUSP) |=> $stable(ecnt_q));

    // R7
    prot_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PROT) |=> (st_q == ST_PROT || st_q == ST_READ || st_q == ST_SUSP));

    // R12
    fail_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FAIL) |=> (st_q == ST_FAIL || st_q == ST_READ));

    // R5
    erase_end_chk: assert property (@(posedge clk) disable iff (rst)
        arr_ers_en_o |=> (st_q == ST_READ));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ARR_W     = 7,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 120,
    parameter int PROT_CYC  = 200,
    parameter bit FORCE_TIMEOUT = 1'b0,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout
);

    logic              wr_stb, rd_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ARR_W-1:0]  rd_idx;
    op_state_e         state;
    op_kind_e          kind;
    logic              prog_msb;
    logic [SECT_W-1:0] esec;
    logic              pgm_en, ers_en;
    logic [ARR_W-1:0]  pgm_idx;
    logic [7:0]        pgm_data;
    logic [7:0]        arr_rdata;

    flash_bus_sampler #(.ADDR_W(ADDR_W), .ARR_W(ARR_W)) u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_idx(rd_idx)
    );

    flash_cmd_engine #(
        .ADDR_W(ADDR_W), .ARR_W(ARR_W), .SECT_W(SECT_W),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_CYC(PROT_CYC),
        .FORCE_TIMEOUT(FORCE_TIMEOUT), .PROT_MASK(PROT_MASK)
    ) u_eng (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .state_o(state), .kind_o(kind),
        .prog_msb_o(prog_msb), .esec_o(esec), .arr_pgm_en_o(pgm_en),
        .arr_pgm_idx_o(pgm_idx), .arr_pgm_data_o(pgm_data),
        .arr_ers_en_o(ers_en)
    );

    flash_cell_array #(.ARR_W(ARR_W), .SECT_W(SECT_W)) u_arr (
        .clk(clk), .rst(rst), .pgm_en(pgm_en), .pgm_idx(pgm_idx),
        .pgm_data(pgm_data), .ers_en(ers_en), .ers_sect(esec),
        .rd_idx(rd_idx), .rd_data(arr_rdata)
    );

    logic              tog6_q, tog2_q;
    logic [7:0]        dout_q;
    logic              busy, on_esec, use_status, flip6, flip2;
    logic [SECT_W-1:0] rd_sect;
    status_t           sword;

    assign rd_sect = rd_idx[ARR_W-1 -: SECT_W];
    assign on_esec = (rd_sect == esec);
    assign busy    = (state == ST_PROG) || (state == ST_PROT)
                  || (state == ST_ERASE) || (state == ST_FAIL);

    always_comb begin
        sword      = '0;
        use_status = 1'b0;
        flip6      = 1'b0;
        flip2      = 1'b0;
        if (busy) begin
            use_status = 1'b1;
            flip6      = 1'b1;
            sword = pack_status((kind == OPK_PROG) ? ~prog_msb : 1'b0, ~tog6_q,
                                (state == ST_FAIL), 1'b0);
            if (state == ST_ERASE && on_esec) begin
                flip2      = 1'b1;
                sword.susp = ~tog2_q;
            end
        end else if (state == ST_SUSP && on_esec) begin
            use_status = 1'b1;
            flip2      = 1'b1;
            sword      = pack_status(1'b1, tog6_q, 1'b0, ~tog2_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 8'hFF;
            tog6_q <= 1'b0;
            tog2_q <= 1'b0;
        end else if (rd_stb) begin
            dout_q <= use_status ? sword : arr_rdata;
            if (flip6) tog6_q <= ~tog6_q;
            if (flip2) tog2_q <= ~tog2_q;
        end
    end

    assign dout = dout_q;

    // R4
    tog_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy) |=> $stable(tog6_q));

    // R1
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb) |=> $stable(dout));

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

    localparam int AW  = 12;
    localparam int PCY = 40;
    localparam int ECY = 120;
    localparam int XCY = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout, dout_to;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // reference model state
    logic [7:0] ref_mem [128];
    logic       tog6_m = 1'b0;
    logic       tog2_m = 1'b0;
    logic [7:0] r1, r2;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(PCY), .ERASE_CYC(ECY), .PROT_CYC(XCY),
                     .FORCE_TIMEOUT(1'b0), .PROT_MASK(4'b1000)) i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout));

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(PCY), .ERASE_CYC(ECY), .PROT_CYC(XCY),
                     .FORCE_TIMEOUT(1'b1), .PROT_MASK(4'b1000)) i_flash_cmd_ctrl_to (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout_to));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write2(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                              input logic [7:0] d);
        @(negedge clk);
        addr = a_fall; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = a_rise; din = d; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write2(a, a, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        r1 = dout; r2 = dout_to;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(12'h555, 8'hA0);
        bus_write(a, d);
    endtask

    task automatic erase_sector(input logic [AW-1:0] a);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(12'h555, 8'h80);
        bus_write(12'h555, 8'hAA);
        bus_write(12'h2AA, 8'h55);
        bus_write(a, 8'h30);
    endtask

    // expected status byte for a busy read; s2 selects a bit-2 toggle
    function automatic logic [7:0] busy_stat(input logic poll, input logic tout, input logic s2);
        tog6_m = ~tog6_m;
        if (s2) tog2_m = ~tog2_m;
        return {poll, tog6_m, tout, 2'b00, s2 ? tog2_m : 1'b0, 2'b00};
    endfunction

    function automatic logic [7:0] susp_stat();
        tog2_m = ~tog2_m;
        return {1'b1, tog6_m, 1'b0, 2'b00, tog2_m, 2'b00};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] e;
        logic       prev6;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1: reset state
        chk("R1 dout after reset", dout, 8'hFF);
        bus_read(12'h010); chk("R1 erased read", r1, 8'hFF);
        chk("R1 erased read timeout instance", r2, 8'hFF);
        bus_read(12'h07F); chk("R1 erased read top", r1, 8'hFF);

        // R2 R3 R4: program with status polling
        program_byte(12'h010, 8'h3C); ref_mem[8'h10] = 8'h3C;
        bus_read(12'h010); e = busy_stat(1'b1, 1'b0, 1'b0); chk("R3 poll complement", r1, e);
        bus_read(12'h010); e = busy_stat(1'b1, 1'b0, 1'b0); chk("R4 toggle flips", r1, e);
        idle(PCY + 4);
        bus_read(12'h010); chk("R2 programmed byte", r1, ref_mem[8'h10]);
        bus_read(12'h010); chk("R4 stable after end", r1, ref_mem[8'h10]);

        // R13: address from falling edge, data from rising edge
        program_byte(12'h020, 8'h00);
        idle(PCY + 4); ref_mem[8'h20] = 8'h00;
        bus_write(12'h555, 8'hAA); bus_write(12'h2AA, 8'h55); bus_write(12'h555, 8'hA0);
        bus_write2(12'h031, 12'h032, 8'h0F); ref_mem[8'h31] = 8'h0F;
        idle(PCY + 4);
        bus_read(12'h031); chk("R13 falling-edge address", r1, 8'h0F);
        bus_read(12'h032); chk("R13 rising-edge address unused", r1, 8'hFF);

        // R2: programming only clears bits
        program_byte(12'h010, 8'hF0); ref_mem[8'h10] = 8'h3C & 8'hF0;
        idle(PCY + 4);
        bus_read(12'h010); chk("R2 AND of old and new", r1, 8'h30);

        // R6: broken sequences
        bus_write(12'h555, 8'hAA); bus_write(12'h2AA, 8'h56);
        bus_write(12'h555, 8'hA0); bus_write(12'h030, 8'h00);
        bus_read(12'h030); chk("R6 bad unlock data", r1, 8'hFF);
        bus_write(12'h555, 8'hAA); bus_write(12'h2AB, 8'h55);
        bus_write(12'h555, 8'hA0); bus_write(12'h033, 8'h00);
        bus_read(12'h033); chk("R6 bad unlock address", r1, 8'hFF);

        // R10: resume byte in read mode is ignored
        bus_write(12'h000, 8'h30);
        bus_read(12'h010); chk("R10 resume ignored", r1, 8'h30);

        // R7: protected sector (sector 3)
        program_byte(12'h070, 8'h00);
        bus_read(12'h070); e = busy_stat(1'b1, 1'b0, 1'b0); chk("R7 protect busy", r1, e);
        bus_read(12'h070); e = busy_stat(1'b1, 1'b0, 1'b0); chk("R7 protect toggle", r1, e);
        idle(XCY + 4);
        bus_read(12'h070); chk("R7 protected data kept", r1, 8'hFF);

        // R5: sector erase of sector 1
        program_byte(12'h040, 8'h11); ref_mem[8'h40] = 8'h11;
        idle(PCY + 4);
        erase_sector(12'h025);
        bus_read(12'h020); e = busy_stat(1'b0, 1'b0, 1'b1); chk("R5 erase status sector", r1, e);
        bus_read(12'h040); e = busy_stat(1'b0, 1'b0, 1'b0); chk("R5 erase status other", r1, e);
        idle(ECY + 4);
        bus_read(12'h020); chk("R5 erased byte", r1, 8'hFF);
        bus_read(12'h031); chk("R5 erased byte 2", r1, 8'hFF);
        bus_read(12'h040); chk("R5 other sector kept", r1, 8'h11);

        // R8 R9 R11: suspend, program while suspended, resume
        program_byte(12'h022, 8'h00);
        idle(PCY + 4);
        erase_sector(12'h022);
        bus_read(12'h022); e = busy_stat(1'b0, 1'b0, 1'b1); chk("R5 erase running", r1, e);
        bus_write(12'h000, 8'hB0);
        bus_read(12'h022); e = susp_stat(); chk("R8 suspended status", r1, e);
        bus_read(12'h022); e = susp_stat(); chk("R8 bit6 frozen bit2 toggles", r1, e);
        bus_read(12'h040); chk("R8 other sector array", r1, 8'h11);
        program_byte(12'h041, 8'h0F);
        bus_read(12'h041); e = busy_stat(1'b1, 1'b0, 1'b0); chk("R11 program in suspend", r1, e);
        idle(PCY + 4);
        bus_read(12'h041); chk("R11 programmed in suspend", r1, 8'h0F);
        bus_read(12'h022); e = susp_stat(); chk("R11 back to suspend", r1, e);
        bus_write(12'h123, 8'h30);
        bus_read(12'h022); e = busy_stat(1'b0, 1'b0, 1'b1); chk("R9 resumed erase", r1, e);
        bus_write(12'h000, 8'hB0);
        bus_read(12'h022); e = susp_stat(); chk("R9 second suspend", r1, e);
        bus_write(12'h000, 8'h30);
        idle(ECY + 4);
        bus_read(12'h022); chk("R9 erase completes", r1, 8'hFF);
        bus_read(12'h041); chk("R9 other sector kept", r1, 8'h0F);

        // R12: forced timeout instance
        bus_write(12'h000, 8'hF0);
        program_byte(12'h050, 8'h5A);
        idle(PCY + 4);
        bus_read(12'h050);
        chk("R12 normal instance completes", r1, 8'h5A);
        chk("R12 timeout flag", {r2[7], r2[5]}, 8'h03);
        prev6 = r2[6];
        bus_read(12'h050);
        chk("R12 bit6 keeps toggling", {7'd0, r2[6] ^ prev6}, 8'h01);
        bus_write(12'h000, 8'hF0);
        bus_read(12'h050);
        chk("R12 reset returns array", r2, 8'hFF);
        chk("R12 normal instance unaffected", r1, 8'h5A);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule